// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits inside a small CPU core. It takes the core from an accepted interrupt request to the first fetch of the handler. The request source presents a number, a priority level and a software-interrupt marker on a valid/ready channel. The sequencer raises ready only when it is idle, the interrupt-enable flag is set, the request outranks the current priority level, and the core is at an instruction boundary or inside an abortable long instruction. A source must hold valid and its fields steady until it sees ready high at a clock edge. A low ready is the only back-pressure and carries no other meaning.

After acceptance the block runs a fixed 20-cycle script on a byte-wide memory bus. Reads return their data one cycle after the read strobe. The script makes an acknowledge read at address zero, which also clears the source's pending bit. It snapshots the flag and PC registers, then clears the enable, single-step and stack-select flags. It pushes the flags and the PC as four staggered byte writes, drops the stack pointer by four, and loads the new priority level. Last, it reads a three-byte vector and hands the assembled 20-bit address to the PC. The CPU register file is reached through plain value-in and value-plus-write-pulse ports.

The flag register is 12 bits wide. The bits that matter are single-step at bit 1, interrupt enable at bit 6, stack select at bit 7 and the priority level in bits 10:8. The stack pointer is 16 bits and is zero-extended onto the 20-bit bus.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted (req_ready high while req_valid is high) only when the block is idle, flag bit 6 is 1, req_level is strictly greater than flag bits 10:8, and at_boundary or long_busy is high. Otherwise req_ready stays 0 and no sequence starts.
- R2: When a request is accepted while long_busy is high and at_boundary is low, instr_abort is 1 in the acceptance cycle. At a boundary, instr_abort stays 0.
- R3: In the cycle after acceptance, the block issues a read at address 0x00000 and pulses irq_clear at the same time.
- R4: Two cycles after the read, flags are written with bit 6 and bit 1 cleared and bit 7 cleared. All other bits keep their values from the snapshot taken before any change.
- R5: When the entry is a software interrupt (req_swi=1) with a number from 32 to 63, bit 7 keeps its snapshot value. Every other entry clears it.
- R6: Four byte writes follow, in this order: SP-2 gets {flags[3:0], PC[19:16]}, SP-1 gets flags[11:4], SP-4 gets PC[7:0], and SP-3 gets PC[15:8]. Flags and PC are the snapshot values.
- R7: After the writes, the stack pointer is written as SP-4, and the flags are written again with bits 10:8 equal to the accepted level.
- R8: The vector bytes are read from VEC, VEC+1 and VEC+2, where VEC = VEC_BASE + 4*number. The new PC is {byte2[3:0], byte1, byte0}.
- R9: done and pc_we pulse for exactly one cycle, 20 cycles after the acceptance edge. busy is high from acceptance until then, and the bus never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_num | input | 6 | Interrupt number |
| req_level | input | 3 | Request priority level |
| req_swi | input | 1 | Request comes from a software interrupt instruction |
| at_boundary | input | 1 | Current instruction has completed |
| long_busy | input | 1 | An abortable long instruction is running |
| instr_abort | output | 1 | Suspend the running long instruction |
| irq_clear | output | 1 | Clear the pending bit of the accepted source |
| mem_rd | output | 1 | Bus read strobe |
| mem_we | output | 1 | Bus write strobe |
| mem_addr | output | 20 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| flg_in | input | 12 | Current flag register |
| flg_we | output | 1 | Flag register write |
| flg_out | output | 12 | New flag value |
| sp_in | input | 16 | Selected stack pointer |
| sp_we | output | 1 | Stack pointer write |
| sp_out | output | 16 | New stack pointer |
| pc_in | input | 20 | Current program counter |
| pc_we | output | 1 | Program counter write |
| pc_out | output | 20 | Handler start address |
| busy | output | 1 | Entry sequence running |
| done | output | 1 | Sequence finished, PC loaded |

## Verification
Some properties are checked on every cycle. Ready is never offered while busy. An accepted request makes busy rise on the next cycle. The bus never reads and writes together. irq_clear and instr_abort only appear around an acceptance, and done is a single pulse that always comes with the PC write. The exact byte contents and order of the stack writes, the flag masking and its software-interrupt exception, the vector address arithmetic, the new stack pointer and the 20-cycle latency depend on data values. Only the bench's scenarios show these, by comparing against its scoreboard and its model of the register file.

// File: rtl/ise_pkg.sv
package ise_pkg;
  localparam int FLG_W   = 12;
  localparam int FLG_D   = 1;
  localparam int FLG_I   = 6;
  localparam int FLG_U   = 7;
  localparam int IPL_LO  = 8;
  localparam int IPL_W   = 3;
  localparam int PC_W    = 20;
  localparam int SEQ_LEN = 20;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  typedef logic [STEP_W-1:0] step_t;

  localparam step_t S_ACK   = step_t'(0);
  localparam step_t S_SNAP  = step_t'(1);
  localparam step_t S_FLG1  = step_t'(2);
  localparam step_t S_SPLAT = step_t'(5);
  localparam step_t S_W0    = step_t'(6);
  localparam step_t S_W1    = step_t'(7);
  localparam step_t S_W2    = step_t'(8);
  localparam step_t S_W3    = step_t'(9);
  localparam step_t S_COMMIT= step_t'(10);
  localparam step_t S_V0    = step_t'(12);
  localparam step_t S_V1    = step_t'(13);
  localparam step_t S_V2    = step_t'(14);
  localparam step_t S_CAP2  = step_t'(15);
  localparam step_t S_LOAD  = step_t'(SEQ_LEN-1);
endpackage

// File: rtl/ise_accept_gate.sv
module ise_accept_gate
  import ise_pkg::*;
#(
  parameter int LVL_W = IPL_W
) (
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             at_boundary,
  input  logic             long_busy,
  input  logic             busy,
  input  logic [FLG_W-1:0] flg_in,
  output logic             ready,
  output logic             accept,
  output logic             abort
);
  logic [IPL_W-1:0] cur_ipl;
  logic             can_break;

  assign cur_ipl   = flg_in[IPL_LO +: IPL_W];
  assign can_break = at_boundary || long_busy;
  assign ready     = !busy && flg_in[FLG_I] && (req_level > cur_ipl) && can_break;
  assign accept    = req_valid && ready;
  assign abort     = accept && long_busy && !at_boundary;
endmodule

// File: rtl/ise_step_ctr.sv
module ise_step_ctr
  import ise_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output logic  busy,
  output step_t step
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (step == S_LOAD) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + step_t'(1);
      end
    end
  end
endmodule

// File: rtl/ise_entry_dp.sv
module ise_entry_dp
  import ise_pkg::*;
#(
  parameter int ADDR_W   = PC_W,
  parameter int NUM_W    = 6,
  parameter int LVL_W    = IPL_W,
  parameter int SP_W     = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 20'h0FE00,
  parameter int SWI_LO   = 32,
  parameter int SWI_HI   = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [LVL_W-1:0]  req_level,
  input  logic              req_swi,
  input  logic              busy,
  input  step_t             step,
  input  logic [7:0]        mem_rdata,
  input  logic [FLG_W-1:0]  flg_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [PC_W-1:0]   pc_in,
  output logic              irq_clear,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              flg_we,
  output logic [FLG_W-1:0]  flg_out,
  output logic              sp_we,
  output logic [SP_W-1:0]   sp_out,
  output logic              pc_we,
  output logic [PC_W-1:0]   pc_out,
  output logic              done
);
  logic [NUM_W-1:0]  num_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              swi_q;
  logic [FLG_W-1:0]  flg_tmp;
  logic [PC_W-1:0]   pc_tmp;
  logic [SP_W-1:0]   sp_q;
  logic [7:0]        vb [3];
  logic [ADDR_W-1:0] vec_addr;
  logic              keep_u;
  logic [FLG_W-1:0]  masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q   <= '0;
      lvl_q   <= '0;
      swi_q   <= 1'b0;
      flg_tmp <= '0;
      pc_tmp  <= '0;
      sp_q    <= '0;
      for (int i = 0; i < 3; i++) vb[i] <= '0;
    end else begin
      if (accept) begin
        num_q <= req_num;
        lvl_q <= req_level;
        swi_q <= req_swi;
      end
      if (busy && step == S_SNAP) begin
        flg_tmp <= flg_in;
        pc_tmp  <= pc_in;
      end
      if (busy && step == S_SPLAT) sp_q <= sp_in;
      if (busy && step == S_V1)   vb[0] <= mem_rdata;
      if (busy && step == S_V2)   vb[1] <= mem_rdata;
      if (busy && step == S_CAP2) vb[2] <= mem_rdata;
    end
  end

  assign vec_addr = VEC_BASE + (ADDR_W'(num_q) << 2);
  assign keep_u   = swi_q && (int'(num_q) >= SWI_LO) && (int'(num_q) <= SWI_HI);

  always_comb begin
    masked        = flg_tmp;
    masked[FLG_I] = 1'b0;
    masked[FLG_D] = 1'b0;
    if (!keep_u) masked[FLG_U] = 1'b0;
  end

  always_comb begin
    irq_clear = 1'b0;
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    flg_we    = 1'b0;
    flg_out   = masked;
    sp_we     = 1'b0;
    sp_out    = sp_q - SP_W'(4);
    pc_we     = 1'b0;
    pc_out    = {vb[2][3:0], vb[1], vb[0]};
    done      = 1'b0;
    if (busy) begin
      case (step)
        S_ACK: begin
          mem_rd    = 1'b1;
          irq_clear = 1'b1;
        end
        S_FLG1: flg_we = 1'b1;
        S_W0: begin
          mem_we    = 1'b1;
          mem_addr  = ADDR_W'(sp_q - SP_W'(2));
          mem_wdata = {flg_tmp[3:0], pc_tmp[19:16]};
        end
        S_W1: begin
          mem_we    = 1'b1;
          mem_addr  = ADDR_W'(sp_q - SP_W'(1));
          mem_wdata = flg_tmp[11:4];
        end
        S_W2: begin
          mem_we    = 1'b1;
          mem_addr  = ADDR_W'(sp_q - SP_W'(4));
          mem_wdata = pc_tmp[7:0];
        end
        S_W3: begin
          mem_we    = 1'b1;
          mem_addr  = ADDR_W'(sp_q - SP_W'(3));
          mem_wdata = pc_tmp[15:8];
        end
        S_COMMIT: begin
          sp_we   = 1'b1;
          flg_we  = 1'b1;
          flg_out[IPL_LO +: IPL_W] = IPL_W'(lvl_q);
        end
        S_V0: begin
          mem_rd   = 1'b1;
          mem_addr = vec_addr;
        end
        S_V1: begin
          mem_rd   = 1'b1;
          mem_addr = vec_addr + ADDR_W'(1);
        end
        S_V2: begin
          mem_rd   = 1'b1;
          mem_addr = vec_addr + ADDR_W'(2);
        end
        S_LOAD: begin
          pc_we = 1'b1;
          done  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ise_pkg::*;
#(
  parameter int ADDR_W = PC_W,
  parameter int NUM_W  = 6,
  parameter int LVL_W  = IPL_W,
  parameter int SP_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 20'h0FE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [LVL_W-1:0]  req_level,
  input  logic              req_swi,
  input  logic              at_boundary,
  input  logic              long_busy,
  output logic              instr_abort,
  output logic              irq_clear,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic [FLG_W-1:0]  flg_in,
  output logic              flg_we,
  output logic [FLG_W-1:0]  flg_out,
  input  logic [SP_W-1:0]   sp_in,
  output logic              sp_we,
  output logic [SP_W-1:0]   sp_out,
  input  logic [PC_W-1:0]   pc_in,
  output logic              pc_we,
  output logic [PC_W-1:0]   pc_out,
  output logic              busy,
  output logic              done
);
  logic  accept;
  step_t step;

  ise_accept_gate #(.LVL_W(LVL_W)) u_gate (
    .req_valid(req_valid), .req_level(req_level), .at_boundary(at_boundary),
    .long_busy(long_busy), .busy(busy), .flg_in(flg_in),
    .ready(req_ready), .accept(accept), .abort(instr_abort)
  );

  ise_step_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .step(step)
  );

  ise_entry_dp #(
    .ADDR_W(ADDR_W), .NUM_W(NUM_W), .LVL_W(LVL_W), .SP_W(SP_W), .VEC_BASE(VEC_BASE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_num(req_num),
    .req_level(req_level), .req_swi(req_swi), .busy(busy), .step(step),
    .mem_rdata(mem_rdata), .flg_in(flg_in), .sp_in(sp_in), .pc_in(pc_in),
    .irq_clear(irq_clear), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .flg_we(flg_we), .flg_out(flg_out), .sp_we(sp_we),
    .sp_out(sp_out), .pc_we(pc_we), .pc_out(pc_out), .done(done)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic mem_rd,
  input logic mem_we,
  input logic irq_clear,
  input logic instr_abort,
  input logic pc_we
);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R9
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_we && busy));
  // R2
  abort_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_abort |-> (req_valid && req_ready));
  // R3
  clear_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (irq_clear && mem_rd));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .mem_rd(mem_rd), .mem_we(mem_we),
  .irq_clear(irq_clear), .instr_abort(instr_abort), .pc_we(pc_we)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] VBASE = 20'h0FE00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_swi = 1'b0;
  logic [5:0]  req_num = '0;
  logic [2:0]  req_level = '0;
  logic        at_boundary = 1'b0, long_busy = 1'b0;
  logic        instr_abort, irq_clear, mem_rd, mem_we, flg_we, sp_we, pc_we, busy, done;
  logic [19:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [11:0] flg_out;
  logic [15:0] sp_out;

  logic [11:0] cpu_flg = '0;
  logic [15:0] cpu_sp  = '0;
  logic [19:0] cpu_pc  = '0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_flg = '0;
  logic [15:0] ld_sp = '0;
  logic [19:0] ld_pc = '0;

  int checks = 0, fails = 0;
  logic [27:0] exp_q[$];

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_level(req_level), .req_swi(req_swi),
    .at_boundary(at_boundary), .long_busy(long_busy), .instr_abort(instr_abort),
    .irq_clear(irq_clear), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .flg_in(cpu_flg), .flg_we(flg_we),
    .flg_out(flg_out), .sp_in(cpu_sp), .sp_we(sp_we), .sp_out(sp_out),
    .pc_in(cpu_pc), .pc_we(pc_we), .pc_out(pc_out), .busy(busy), .done(done)
  );

  function automatic logic [7:0] vbyte(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  always_ff @(posedge clk) mem_rdata <= mem_rd ? vbyte(mem_addr) : 8'h00;

  always @(negedge clk) begin
    if (ld_en) begin
      cpu_flg <= ld_flg; cpu_sp <= ld_sp; cpu_pc <= ld_pc;
    end else begin
      if (flg_we) cpu_flg <= flg_out;
      if (sp_we)  cpu_sp  <= sp_out;
      if (pc_we)  cpu_pc  <= pc_out;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for stack writes (R6)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) check("R6 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'h0);
      else begin
        logic [27:0] e;
        e = exp_q.pop_front();
        check("R6 stack write", {4'h0, mem_addr, mem_wdata}, {4'h0, e});
      end
    end
  end

  task automatic load_regs(logic [11:0] f, logic [15:0] s, logic [19:0] p);
    ld_flg = f; ld_sp = s; ld_pc = p; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_block(string req, logic [5:0] n, logic [2:0] l, logic b, logic lb);
    req_num = n; req_level = l; req_swi = 1'b0; at_boundary = b; long_busy = lb;
    req_valid = 1'b1;
    #1 check(req, {31'h0, req_ready}, 32'h0);
    repeat (3) @(negedge clk);
    check(req, {31'h0, busy}, 32'h0);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_irq(logic [5:0] n, logic [2:0] l, logic swi, logic b, logic lb);
    logic [11:0] f0, fexp;
    logic [15:0] s0;
    logic [19:0] p0, va, pexp;
    int cnt;
    bit seen;
    f0 = cpu_flg; s0 = cpu_sp; p0 = cpu_pc;
    exp_q.push_back({20'(s0 - 16'd2), f0[3:0], p0[19:16]});
    exp_q.push_back({20'(s0 - 16'd1), f0[11:4]});
    exp_q.push_back({20'(s0 - 16'd4), p0[7:0]});
    exp_q.push_back({20'(s0 - 16'd3), p0[15:8]});
    va = VBASE + {12'h0, n, 2'b00};
    pexp = {vbyte(va + 20'd2)[3:0], vbyte(va + 20'd1), vbyte(va)};
    fexp = f0; fexp[6] = 1'b0; fexp[1] = 1'b0;
    if (!(swi && n >= 6'd32)) fexp[7] = 1'b0;
    fexp[10:8] = l;
    req_num = n; req_level = l; req_swi = swi; at_boundary = b; long_busy = lb;
    req_valid = 1'b1;
    #1 check("R1 ready", {31'h0, req_ready}, 32'h1);
    check("R2 abort", {31'h0, instr_abort}, {31'h0, lb && !b});
    @(posedge clk);
    #1 req_valid = 1'b0; at_boundary = 1'b0; long_busy = 1'b0;
    cnt = 0; seen = 0;
    while (!seen && cnt < 40) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        check("R3 ack read", {31'h0, mem_rd && irq_clear}, 32'h1);
        check("R3 ack addr", {12'h0, mem_addr}, 32'h0);
      end
      if (cnt == 2) check("R9 busy", {31'h0, busy}, 32'h1);
      if (cnt == 3) begin
        check("R4 first flag write", {31'h0, flg_we}, 32'h1);
        check("R4/R5 masked flags", {20'h0, flg_out},
              {20'h0, fexp[11], f0[10:8], fexp[7:0]});
      end
      if (done) begin
        seen = 1;
        check("R8 pc vector", {12'h0, pc_out}, {12'h0, pexp});
      end
    end
    check("R9 latency", cnt, 32'd20);
    @(negedge clk);
    check("R9 done pulse", {31'h0, done}, 32'h0);
    check("R7 sp", {16'h0, cpu_sp}, {16'h0, 16'(s0 - 16'd4)});
    check("R7 flags ipl", {20'h0, cpu_flg}, {20'h0, fexp});
    check("R6 queue drained", exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset busy", {31'h0, busy}, 32'h0);
    check("R9 reset done", {31'h0, done}, 32'h0);
    check("R9 reset bus", {30'h0, mem_rd, mem_we}, 32'h0);

    // flags: ipl=2, U, I, D set, plus other bits
    load_regs(12'h2E7, 16'h0400, 20'hABC12);
    run_irq(6'd3, 3'd5, 1'b0, 1'b1, 1'b0);

    load_regs(12'h0C2 | 12'h300, cpu_sp, cpu_pc);   // ipl 3
    expect_block("R1 level equal", 6'd4, 3'd3, 1'b1, 1'b0);
    expect_block("R1 no boundary", 6'd4, 3'd6, 1'b0, 1'b0);
    load_regs(12'h082 | 12'h100, cpu_sp, cpu_pc);   // I=0
    expect_block("R1 disabled", 6'd4, 3'd7, 1'b1, 1'b0);

    load_regs(12'h1C3, cpu_sp, cpu_pc);
    run_irq(6'd7, 3'd4, 1'b0, 1'b0, 1'b1);          // R2 abort path
    load_regs(12'h0C2, cpu_sp, cpu_pc);
    run_irq(6'd40, 3'd2, 1'b1, 1'b1, 1'b0);         // R5 keep U
    load_regs(12'h0C2, cpu_sp, cpu_pc);
    run_irq(6'd10, 3'd2, 1'b1, 1'b1, 1'b0);         // R5 swi below range
    load_regs(12'h0C2, cpu_sp, cpu_pc);
    run_irq(6'd40, 3'd1, 1'b0, 1'b1, 1'b0);         // R5 hardware at 40
    load_regs(12'hFFF & ~12'h700, 16'h0002, 20'h00001);
    run_irq(6'd63, 3'd7, 1'b1, 1'b1, 1'b1);         // R5/R7 upper edge, sp wrap

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule